// File: doc/BRIEF.md
# Fixed-Point Proportional-Integral Loop Controller

This block is the discrete PI stage of a digital power-factor-correction loop. A sample arrives as a reference and a measured value, both signed 16-bit fractions with 15 fraction bits (range -1 up to just below +1). The block forms the error as reference minus measurement and runs it through a proportional path and a rectangle-rule integral path. The integral path keeps a running sum of every accepted error. Its result is a signed 16-bit word with 11 fraction bits, which leaves four integer bits so that gains and outputs above one fit. When enabled, the same result is also given as an unsigned PWM duty count.

The proportional gain and the per-sample integral gain (integral gain times sample period) are signed 16-bit inputs. By default they have 11 fraction bits. The fraction counts of the input, the gains and the output are parameters, and the internal shift is derived from them. Products and the running sum use wide internal precision. The running sum saturates instead of wrapping, which acts as anti-windup. A synchronous clear input empties the sum.

The sample input and the result output are valid/ready streams. A sample is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while no result is waiting. A result appears on the clock edge after its sample is taken. It stays valid and unchanged until a cycle with `out_ready` high, so the consumer stalls the block by holding `out_ready` low. Samples offered during a stall are not taken and do not touch the running sum.

Top module: `pfc_pi_ctrl`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the running error sum is zero.
- R2: For an accepted sample, the error is e = ref_in - meas_in, computed as a 17-bit signed value in units of 2^-15. The result is u_out = floor((kp*e + ki*S)/2^15), read as 11 fraction bits. Here S is the running sum after the current error has been added.
- R3: The running sum changes only on accepted samples. Each accepted sample adds its error to the sum.
- R4: When the unclamped result exceeds the signed 16-bit range, u_out is 32767 above the range and -32768 below it.
- R5: The running sum is held within [-2^23, 2^23-1]. A sample that would push it past a limit leaves it at that limit. The next error of the opposite sign moves it away from the limit at once.
- R6: With `clr` high and no sample accepted, the sum becomes zero on that edge. If `clr` is high in the same cycle a sample is accepted, the earlier sum is treated as zero, and the new sum equals that sample's error.
- R7: duty_out is 0 when u_out is negative. It is 2048 (the PWM period count, the value 1.0 in the output format) when u_out exceeds 2048. Otherwise it equals u_out.
- R8: out_valid rises on the edge after an accepted sample. While out_valid is high and out_ready is low, u_out and duty_out hold their values and in_ready stays low. out_valid falls on an edge where out_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the running error sum |
| kp | input | 16 | Proportional gain, signed, 11 fraction bits by default |
| ki | input | 16 | Integral gain times sample period, signed, 11 fraction bits by default |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| ref_in | input | 16 | Reference, signed, 15 fraction bits |
| meas_in | input | 16 | Measured value, signed, 15 fraction bits |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| u_out | output | 16 | Control result, signed, 11 fraction bits |
| duty_out | output | 12 | Unsigned duty count, 0 to 2048 |

## Verification
The clear of the running sum and the intake of a new sample can land on the same clock edge. The bench provokes this by raising `clr` together with `in_valid` while the block is idle, after first building up a non-zero sum. The bench judges the collision by the result of that sample and of a later probe sample that has zero proportional gain, so its value shows the running sum directly. Both results must match a sum restarted from the colliding error alone. A second overlap is a sample offered while a result is stalled. The bench checks that the held result does not move and that the later probe shows the sum unchanged.

// File: rtl/pfc_pi_pkg.sv
package pfc_pi_pkg;
  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_HIGH = 2'd1,
    CLIP_LOW  = 2'd2
  } clip_kind_e;
endpackage

// File: rtl/pi_integrator.sv
module pi_integrator
  import pfc_pi_pkg::*;
#(
  parameter int ERR_W = 17,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step,
  input  logic signed [ERR_W-1:0] err,
  output logic signed [ACC_W-1:0] sum_q,
  output logic signed [ACC_W-1:0] sum_next
);
  localparam logic signed [ACC_W-1:0] SUM_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SUM_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W:0]   wide;
  clip_kind_e              clip;

  always_comb begin
    base = clr ? '0 : sum_q;
    wide = $signed({base[ACC_W-1], base}) + (ACC_W+1)'(err);
    if (wide[ACC_W] == wide[ACC_W-1]) clip = CLIP_NONE;
    else if (wide[ACC_W])             clip = CLIP_LOW;
    else                              clip = CLIP_HIGH;
    case (clip)
      CLIP_HIGH: sum_next = SUM_MAX;
      CLIP_LOW:  sum_next = SUM_MIN;
      default:   sum_next = wide[ACC_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sum_q <= '0;
    else if (step)  sum_q <= sum_next;
    else if (clr)   sum_q <= '0;
  end
endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage
  import pfc_pi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int ERR_W  = 17,
  parameter int ACC_W  = 24,
  parameter int PROD_W = 42,
  parameter int SHIFT  = 15
) (
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [ERR_W-1:0]  err,
  input  logic signed [ACC_W-1:0]  integ,
  output logic signed [DATA_W-1:0] u
);
  localparam logic signed [PROD_W-1:0] U_HI =
    $signed({{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PROD_W-1:0] U_LO = ~U_HI;

  logic signed [PROD_W-1:0] p_term, i_term, total, scaled;
  clip_kind_e               clip;

  always_comb begin
    p_term = PROD_W'(kp) * PROD_W'(err);
    i_term = PROD_W'(ki) * PROD_W'(integ);
    total  = p_term + i_term;
    scaled = total >>> SHIFT;
    if (scaled > U_HI)      clip = CLIP_HIGH;
    else if (scaled < U_LO) clip = CLIP_LOW;
    else                    clip = CLIP_NONE;
    case (clip)
      CLIP_HIGH: u = {1'b0, {(DATA_W-1){1'b1}}};
      CLIP_LOW:  u = {1'b1, {(DATA_W-1){1'b0}}};
      default:   u = scaled[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/pi_duty_map.sv
module pi_duty_map #(
  parameter int DATA_W     = 16,
  parameter int PERIOD_MAX = 2048,
  parameter int DUTY_W     = 12
) (
  input  logic signed [DATA_W-1:0] u,
  output logic        [DUTY_W-1:0] duty
);
  localparam logic [DATA_W-1:0] TOP = DATA_W'(PERIOD_MAX);

  always_comb begin
    if (u[DATA_W-1])             duty = '0;
    else if ($unsigned(u) > TOP) duty = DUTY_W'(PERIOD_MAX);
    else                         duty = u[DUTY_W-1:0];
  end
endmodule

// File: rtl/pfc_pi_ctrl.sv
module pfc_pi_ctrl #(
  parameter int DATA_W     = 16,
  parameter int GAIN_W     = 16,
  parameter int IN_FRAC    = 15,
  parameter int GAIN_FRAC  = 11,
  parameter int OUT_FRAC   = 11,
  parameter int ACC_W      = 24,
  parameter int PERIOD_MAX = 2048,
  parameter bit DUTY_EN    = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic signed [GAIN_W-1:0]          kp,
  input  logic signed [GAIN_W-1:0]          ki,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic signed [DATA_W-1:0]          ref_in,
  input  logic signed [DATA_W-1:0]          meas_in,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic signed [DATA_W-1:0]          u_out,
  output logic [$clog2(PERIOD_MAX+1)-1:0]   duty_out
);
  localparam int ERR_W  = DATA_W + 1;
  localparam int SHIFT  = IN_FRAC + GAIN_FRAC - OUT_FRAC;
  localparam int PROD_W = GAIN_W + ACC_W + 2;
  localparam int DUTY_W = $clog2(PERIOD_MAX + 1);

  logic                    take;
  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] sum_q, sum_next;
  logic signed [DATA_W-1:0] u_c;
  logic [DUTY_W-1:0]       duty_c;
  logic                    vld_q;

  assign in_ready = !vld_q;
  assign take     = in_valid && !vld_q;
  assign err      = ERR_W'(ref_in) - ERR_W'(meas_in);

  pi_integrator #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(take), .err(err),
    .sum_q(sum_q), .sum_next(sum_next)
  );

  pi_out_stage #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .ERR_W(ERR_W), .ACC_W(ACC_W),
    .PROD_W(PROD_W), .SHIFT(SHIFT)
  ) u_out_stage (
    .kp(kp), .ki(ki), .err(err), .integ(sum_next), .u(u_c)
  );

  generate
    if (DUTY_EN) begin : g_duty
      pi_duty_map #(.DATA_W(DATA_W), .PERIOD_MAX(PERIOD_MAX), .DUTY_W(DUTY_W)) u_duty (
        .u(u_c), .duty(duty_c)
      );
    end else begin : g_noduty
      assign duty_c = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      u_out    <= '0;
      duty_out <= '0;
    end else if (take) begin
      vld_q    <= 1'b1;
      u_out    <= u_c;
      duty_out <= duty_c;
    end else if (out_ready) begin
      vld_q    <= 1'b0;
    end
  end

  assign out_valid = vld_q;
endmodule

// File: rtl/pfc_pi_chk.sv
module pfc_pi_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 24,
  parameter int PMAX   = 2048,
  parameter int DUTY_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] u_out,
  input logic [DUTY_W-1:0]        duty_out,
  input logic signed [ACC_W-1:0]  sum_q
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(u_out) && $stable(duty_out)); // R8
  AST_SUM_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !clr |=> $stable(sum_q)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(in_valid && in_ready) |=> sum_q == '0); // R6
  AST_DUTY_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && u_out[DATA_W-1] |-> duty_out == '0); // R7
  AST_DUTY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> duty_out <= DUTY_W'(PMAX)); // R7
endmodule

bind pfc_pi_ctrl pfc_pi_chk #(
  .DATA_W(DATA_W), .ACC_W(ACC_W), .PMAX(PERIOD_MAX), .DUTY_W($clog2(PERIOD_MAX+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .u_out(u_out), .duty_out(duty_out),
  .sum_q(sum_q)
);

// File: tb/pfc_pi_ctrl_test.sv
`timescale 1ns/1ps
module pfc_pi_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic signed [15:0] kp = '0, ki = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] ref_in = '0, meas_in = '0;
  logic in_ready, out_valid;
  logic signed [15:0] u_out;
  logic [11:0] duty_out;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  longint model_s = 0;

  always #2 clk = ~clk;

  pfc_pi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .kp(kp), .ki(ki),
    .in_valid(in_valid), .in_ready(in_ready), .ref_in(ref_in), .meas_in(meas_in),
    .out_valid(out_valid), .out_ready(out_ready), .u_out(u_out), .duty_out(duty_out)
  );

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic predict(longint e, bit clrx, output longint u, output longint d);
    longint s, t;
    s = clrx ? 0 : model_s;
    s = clampv(s + e, -(64'sd1 <<< 23), (64'sd1 <<< 23) - 1);
    model_s = s;
    t = longint'(kp) * e + longint'(ki) * s;
    u = clampv(t >>> 15, -32768, 32767);
    d = (u < 0) ? 0 : ((u > 2048) ? 2048 : u);
  endtask

  // one sample through the idle block, results checked one edge later
  task automatic send(longint r, longint m, bit clrx, string tag);
    longint eu, ed;
    @(negedge clk);
    ref_in = 16'(r); meas_in = 16'(m); clr = clrx; in_valid = 1'b1;
    predict(r - m, clrx, eu, ed);
    @(negedge clk);
    chk({tag, " valid"}, longint'(out_valid), 1);
    chk({tag, " u"}, longint'(u_out), eu);
    chk({tag, " duty"}, longint'(duty_out), ed);
    in_valid = 1'b0; clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out_valid after reset", longint'(out_valid), 0);
    chk("R1 in_ready after reset", longint'(in_ready), 1);
    kp = 16'sd0; ki = 16'sd64;
    send(0, 0, 1'b0, "R1 empty sum probe");
  endtask

  task automatic t_basic();
    kp = 16'sd3072; ki = 16'sd512;
    send(8000, 2000, 1'b0, "R2 pos error");
    send(-5000, 3000, 1'b0, "R2 neg error");
    send(32767, -32768, 1'b0, "R2 max error");
    send(100, 100, 1'b0, "R3 zero error keeps sum");
    kp = -16'sd700; ki = 16'sd2047;
    send(-12000, 9000, 1'b0, "R2 neg gain");
  endtask

  task automatic t_out_sat();
    kp = 16'sh7fff; ki = 16'sd0;
    send(32767, -32768, 1'b0, "R4 high clip");
    send(-32768, 32767, 1'b0, "R4 low clip");
  endtask

  task automatic t_sum_sat();
    kp = 16'sd0; ki = 16'sd64;
    send(0, 0, 1'b1, "R6 clear before windup");
    for (int i = 0; i < 130; i++) send(32767, -32768, 1'b0, "R5 windup");
    chk("R5 model at ceiling", model_s, (64'sd1 <<< 23) - 1);
    send(-32768, 32767, 1'b0, "R5 unwind at once");
    for (int i = 0; i < 260; i++) send(-32768, 32767, 1'b0, "R5 low windup");
    send(32767, -32768, 1'b0, "R5 unwind from floor");
  endtask

  task automatic t_clear();
    kp = 16'sd0; ki = 16'sd2047;
    send(0, 0, 1'b1, "R6 start clean");
    send(6000, 0, 1'b0, "R6 build sum");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; model_s = 0;
    send(0, 0, 1'b0, "R6 clear alone");
    send(9000, 0, 1'b0, "R6 rebuild sum");
    send(-4000, 0, 1'b1, "R6 clear with sample");
    send(0, 0, 1'b0, "R6 probe after collision");
  endtask

  task automatic t_duty();
    kp = 16'sd2048; ki = 16'sd0;
    send(-100, 0, 1'b0, "R7 negative to zero");
    send(16000, 0, 1'b0, "R7 in range");
    send(16384, 16384, 1'b0, "R7 zero");
    send(32767, -1, 1'b0, "R7 exactly period");
    send(32767, -7233, 1'b0, "R7 above period");
  endtask

  task automatic t_stall();
    longint eu, ed;
    kp = 16'sd1000; ki = 16'sd300;
    send(0, 0, 1'b1, "R8 clean start");
    @(negedge clk);
    out_ready = 1'b0; ref_in = 16'sd12000; meas_in = -16'sd3000; in_valid = 1'b1;
    predict(15000, 1'b0, eu, ed);
    @(negedge clk);
    chk("R8 valid after accept", longint'(out_valid), 1);
    chk("R8 u after accept", longint'(u_out), eu);
    ref_in = 16'sd30000; meas_in = -16'sd30000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 held valid", longint'(out_valid), 1);
      chk("R8 held u", longint'(u_out), eu);
      chk("R8 held duty", longint'(duty_out), ed);
      chk("R8 not ready while held", longint'(in_ready), 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R8 valid drops on ready", longint'(out_valid), 0);
    kp = 16'sd0; ki = 16'sd2047;
    send(0, 0, 1'b0, "R3 stalled offer not summed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_out_sat();
    t_clear();
    t_duty();
    t_sum_sat();
    t_stall();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule